// File: doc/BRIEF.md
# I2C Bus Clock and Data-Edge Pacer

This block paces an I2C controller's bit clock. It holds four cycle counts: a high and a low period for standard speed, and a high and a low period for fast speed. It also holds a data hold delay and a data setup delay. A speed select chooses which pair of periods drives SCL. The settings are captured only while the controller is disabled, so a transfer always runs with one fixed set of timings.

The bus engine asks for a start condition. The pacer then keeps SCL high for one high period, pulls it low and toggles it without a break. It emits single-cycle strobes for the start condition, each SCL fall, each SCL release and the point in each low phase where the engine may change SDA. When the engine asks for a stop, the next high phase ends with a stop strobe in place of a fall, and the pacer returns to idle. The high phase is timed from the cycle SCL is first seen high on the bus. A target that holds SCL low therefore stretches the clock instead of shortening the high time.

The SDA change point is placed a hold delay after the fall. It is then moved earlier if needed, so that SDA is stable for the setup time before the next release.

Top module: `i2c_bit_pacer`

## Requirements
- R1: After reset, every strobe output is low and `scl_drive_low` is low.
- R2: With `fast_sel` = 0, SCL is driven low for `std_lo_cnt` cycles from `scl_fall_stb` to `scl_rise_stb`. With no stretching, the next `scl_fall_stb` comes `std_hi_cnt` cycles after `scl_rise_stb`.
- R3: With `fast_sel` = 1, the low and high periods are taken from `fast_lo_cnt` and `fast_hi_cnt` instead.
- R4: A high count below 6 is used as 6, and a low count below 8 is used as 8.
- R5: When bit 8 of `sda_hold_cfg` is 1, `sda_chg_stb` comes (`sda_hold_cfg[7:0]` + 1) cycles after `scl_fall_stb`, provided the setup rule of R7 does not move it.
- R6: When bit 8 of `sda_hold_cfg` is 0, `sda_chg_stb` comes 1 cycle after `scl_fall_stb`, whatever the value of bits 7:0.
- R7: `sda_chg_stb` comes at least (`sda_setup_cnt` − 1) cycles before the following `scl_rise_stb`. If the hold delay would break this, the change point moves earlier, but never to less than 1 cycle after the fall. A setup count of 0 is used as 1.
- R8: The high phase begins in the first cycle that `scl_in` is sampled high after a release. A target holding SCL low for k extra cycles delays the next fall by k cycles.
- R9: The count, hold, setup and speed inputs are captured only in cycles where `enable` is low. Changing them while `enable` is high has no effect on the timing.
- R10: A `start_req` in idle gives `start_stb` the next cycle. The first `scl_fall_stb` follows one high period later. No two strobes are ever high in the same cycle.
- R11: A `stop_req` during a transfer makes the next high phase end with `stop_stb` one high period after the release, instead of a fall. The block then returns to idle with SCL released.
- R12: While `enable` is low, `start_req` is ignored. Dropping `enable` during a transfer releases SCL on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enabled; settings are frozen while high |
| fast_sel | input | 1 | 0 selects the standard pair, 1 selects the fast pair |
| std_hi_cnt | input | 16 | Standard-speed SCL high cycles |
| std_lo_cnt | input | 16 | Standard-speed SCL low cycles |
| fast_hi_cnt | input | 16 | Fast-speed SCL high cycles |
| fast_lo_cnt | input | 16 | Fast-speed SCL low cycles |
| sda_hold_cfg | input | 9 | Bit 8 enables the hold delay; bits 7:0 give the hold count |
| sda_setup_cnt | input | 8 | Setup count; setup time is this value minus 1 |
| start_req | input | 1 | Bus engine asks for a start condition |
| stop_req | input | 1 | Bus engine asks for a stop after the current bit |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | Pull SCL low while high |
| scl_fall_stb | output | 1 | One-cycle strobe: SCL has just been pulled low |
| scl_rise_stb | output | 1 | One-cycle strobe: SCL has just been released |
| sda_chg_stb | output | 1 | One-cycle strobe: SDA may change now |
| start_stb | output | 1 | One-cycle strobe: drive the start condition |
| stop_stb | output | 1 | One-cycle strobe: drive the stop condition |

## Verification
Transfers are run with the standard pair and then the fast pair, using distinct values. A swapped pair or a wrong select therefore shows up as a wrong low or high length. Counts below the floors show whether clamping is applied to each period. Three hold and setup cases are run: hold enabled, hold disabled with a nonzero count, and a long hold pulled back by setup. Together they tell apart placement from the hold count, the default one-cycle point and placement from the setup limit. A stretched release, a settings change made while enabled, a start made while disabled and a mid-transfer disable show that timing follows the bus line and the frozen settings, not the live inputs.

// File: rtl/i2c_tim_pkg.sv
package i2c_tim_pkg;

  // Floors applied to the programmed SCL periods
  localparam int MIN_HI = 6;
  localparam int MIN_LO = 8;

  // Order of the shadow count slots
  localparam int SLOT_STD_HI  = 0;
  localparam int SLOT_STD_LO  = 1;
  localparam int SLOT_FAST_HI = 2;
  localparam int SLOT_FAST_LO = 3;
  localparam int NUM_SLOTS    = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } phase_t;

endpackage

// File: rtl/i2c_tim_cfg.sv
module i2c_tim_cfg
  import i2c_tim_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int HOLD_W  = 8,
  parameter int SETUP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fast_sel,
  input  logic [CNT_W-1:0]  std_hi_cnt,
  input  logic [CNT_W-1:0]  std_lo_cnt,
  input  logic [CNT_W-1:0]  fast_hi_cnt,
  input  logic [CNT_W-1:0]  fast_lo_cnt,
  input  logic [HOLD_W:0]   sda_hold_cfg,
  input  logic [SETUP_W-1:0] sda_setup_cnt,
  output logic [CNT_W-1:0]  hi_eff,
  output logic [CNT_W-1:0]  lo_eff,
  output logic [CNT_W-1:0]  chg_pos
);

  localparam int EXT_W = CNT_W + 2;

  logic load_en;
  assign load_en = !enable;

  logic [CNT_W-1:0] cnt_in  [NUM_SLOTS];
  logic [CNT_W-1:0] cnt_all [NUM_SLOTS];

  assign cnt_in[SLOT_STD_HI]  = std_hi_cnt;
  assign cnt_in[SLOT_STD_LO]  = std_lo_cnt;
  assign cnt_in[SLOT_FAST_HI] = fast_hi_cnt;
  assign cnt_in[SLOT_FAST_LO] = fast_lo_cnt;

  // One shadow register per count slot, loaded only while disabled
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [CNT_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= CNT_W'(MIN_LO);
      end else if (load_en) begin
        slot_q <= cnt_in[g];
      end
    end
    assign cnt_all[g] = slot_q;
  end

  logic              fast_q;
  logic [HOLD_W:0]   hold_q;
  logic [SETUP_W-1:0] setup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q  <= 1'b0;
      hold_q  <= '0;
      setup_q <= SETUP_W'(1);
    end else if (load_en) begin
      fast_q  <= fast_sel;
      hold_q  <= sda_hold_cfg;
      setup_q <= sda_setup_cnt;
    end
  end

  logic [CNT_W-1:0] sel_hi, sel_lo;
  assign sel_hi = fast_q ? cnt_all[SLOT_FAST_HI] : cnt_all[SLOT_STD_HI];
  assign sel_lo = fast_q ? cnt_all[SLOT_FAST_LO] : cnt_all[SLOT_STD_LO];

  always_comb begin
    hi_eff = (sel_hi < CNT_W'(MIN_HI)) ? CNT_W'(MIN_HI) : sel_hi;
    lo_eff = (sel_lo < CNT_W'(MIN_LO)) ? CNT_W'(MIN_LO) : sel_lo;
  end

  // Place the SDA change point: hold delay after the fall, pulled back to
  // respect setup before the release, kept inside the low phase.
  logic [EXT_W-1:0] hold_dly, setup_eff, lim, cand, lo_ext;

  always_comb begin
    lo_ext    = EXT_W'(lo_eff);
    hold_dly  = hold_q[HOLD_W] ? (EXT_W'(hold_q[HOLD_W-1:0]) + EXT_W'(1))
                               : EXT_W'(1);
    setup_eff = (setup_q == '0) ? EXT_W'(1) : EXT_W'(setup_q);
    lim       = ((lo_ext + EXT_W'(1)) >= setup_eff) ?
                (lo_ext + EXT_W'(1) - setup_eff) : '0;
    cand      = (hold_dly < lim) ? hold_dly : lim;
    if (cand == '0) begin
      cand = EXT_W'(1);
    end
    if (cand > (lo_ext - EXT_W'(1))) begin
      cand = lo_ext - EXT_W'(1);
    end
    chg_pos = cand[CNT_W-1:0];
  end

  // R4
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_eff >= CNT_W'(MIN_HI)) && (lo_eff >= CNT_W'(MIN_LO)));

  // R9
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |->
      ($stable(hi_eff) && $stable(lo_eff) && $stable(chg_pos)));

endmodule

// File: rtl/i2c_scl_fsm.sv
module i2c_scl_fsm
  import i2c_tim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] hi_eff,
  input  logic [CNT_W-1:0] lo_eff,
  input  logic [CNT_W-1:0] chg_pos,
  output logic             scl_drive_low,
  output logic             scl_fall_stb,
  output logic             scl_rise_stb,
  output logic             sda_chg_stb,
  output logic             start_stb,
  output logic             stop_stb
);

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             fall_d, rise_d, start_d, stop_d;
  logic             fall_q, rise_q, start_q, stop_q;

  logic hi_last, lo_last;
  assign hi_last = (cnt_q == (hi_eff - CNT_W'(1)));
  assign lo_last = (cnt_q == (lo_eff - CNT_W'(1)));

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    fall_d  = 1'b0;
    rise_d  = 1'b0;
    start_d = 1'b0;
    stop_d  = 1'b0;
    if (!enable) begin
      ph_d   = PH_IDLE;
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      if (ph_q != PH_IDLE && stop_req) begin
        pend_d = 1'b1;
      end
      unique case (ph_q)
        PH_IDLE: begin
          if (start_req) begin
            ph_d    = PH_START;
            cnt_d   = '0;
            pend_d  = 1'b0;
            start_d = 1'b1;
          end
        end
        PH_START: begin
          if (hi_last) begin
            ph_d   = PH_LOW;
            cnt_d  = '0;
            fall_d = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_LOW: begin
          if (lo_last) begin
            ph_d   = PH_WAIT;
            cnt_d  = '0;
            rise_d = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_WAIT: begin
          // the cycle SCL is first seen high counts as the first high cycle
          if (scl_in) begin
            ph_d  = PH_HIGH;
            cnt_d = CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (hi_last) begin
            if (pend_q || stop_req) begin
              ph_d   = PH_IDLE;
              cnt_d  = '0;
              pend_d = 1'b0;
              stop_d = 1'b1;
            end else begin
              ph_d   = PH_LOW;
              cnt_d  = '0;
              fall_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      fall_q  <= fall_d;
      rise_q  <= rise_d;
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  assign scl_drive_low = (ph_q == PH_LOW);
  assign scl_fall_stb  = fall_q;
  assign scl_rise_stb  = rise_q;
  assign start_stb     = start_q;
  assign stop_stb      = stop_q;
  assign sda_chg_stb   = (ph_q == PH_LOW) && (cnt_q == chg_pos);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_stb, stop_stb, scl_fall_stb, scl_rise_stb, sda_chg_stb}));

  // R5
  sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_chg_stb |-> scl_drive_low);

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ph_q == PH_WAIT && !scl_in) |=> (!scl_fall_stb && !stop_stb));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |-> !scl_drive_low);

  // R12
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !start_stb));

endmodule

// File: rtl/i2c_bit_pacer.sv
module i2c_bit_pacer
  import i2c_tim_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int HOLD_W  = 8,
  parameter int SETUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               fast_sel,
  input  logic [CNT_W-1:0]   std_hi_cnt,
  input  logic [CNT_W-1:0]   std_lo_cnt,
  input  logic [CNT_W-1:0]   fast_hi_cnt,
  input  logic [CNT_W-1:0]   fast_lo_cnt,
  input  logic [HOLD_W:0]    sda_hold_cfg,
  input  logic [SETUP_W-1:0] sda_setup_cnt,
  input  logic               start_req,
  input  logic               stop_req,
  input  logic               scl_in,
  output logic               scl_drive_low,
  output logic               scl_fall_stb,
  output logic               scl_rise_stb,
  output logic               sda_chg_stb,
  output logic               start_stb,
  output logic               stop_stb
);

  logic [CNT_W-1:0] hi_eff, lo_eff, chg_pos;

  i2c_tim_cfg #(
    .CNT_W  (CNT_W),
    .HOLD_W (HOLD_W),
    .SETUP_W(SETUP_W)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .fast_sel     (fast_sel),
    .std_hi_cnt   (std_hi_cnt),
    .std_lo_cnt   (std_lo_cnt),
    .fast_hi_cnt  (fast_hi_cnt),
    .fast_lo_cnt  (fast_lo_cnt),
    .sda_hold_cfg (sda_hold_cfg),
    .sda_setup_cnt(sda_setup_cnt),
    .hi_eff       (hi_eff),
    .lo_eff       (lo_eff),
    .chg_pos      (chg_pos)
  );

  i2c_scl_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .start_req    (start_req),
    .stop_req     (stop_req),
    .scl_in       (scl_in),
    .hi_eff       (hi_eff),
    .lo_eff       (lo_eff),
    .chg_pos      (chg_pos),
    .scl_drive_low(scl_drive_low),
    .scl_fall_stb (scl_fall_stb),
    .scl_rise_stb (scl_rise_stb),
    .sda_chg_stb  (sda_chg_stb),
    .start_stb    (start_stb),
    .stop_stb     (stop_stb)
  );

endmodule

// File: tb/i2c_bit_pacer_tb.sv
`timescale 1ns/1ps
module i2c_bit_pacer_tb;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        fast_sel;
  logic [15:0] std_hi_cnt, std_lo_cnt, fast_hi_cnt, fast_lo_cnt;
  logic [8:0]  sda_hold_cfg;
  logic [7:0]  sda_setup_cnt;
  logic        start_req, stop_req, scl_in, slave_hold;
  logic        scl_drive_low, scl_fall_stb, scl_rise_stb, sda_chg_stb;
  logic        start_stb, stop_stb;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  assign scl_in = !scl_drive_low && !slave_hold;

  i2c_bit_pacer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
    .std_hi_cnt(std_hi_cnt), .std_lo_cnt(std_lo_cnt),
    .fast_hi_cnt(fast_hi_cnt), .fast_lo_cnt(fast_lo_cnt),
    .sda_hold_cfg(sda_hold_cfg), .sda_setup_cnt(sda_setup_cnt),
    .start_req(start_req), .stop_req(stop_req), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .scl_fall_stb(scl_fall_stb),
    .scl_rise_stb(scl_rise_stb), .sda_chg_stb(sda_chg_stb),
    .start_stb(start_stb), .stop_stb(stop_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = !clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // program settings with the controller disabled, then enable it
  task automatic setup_cfg(input bit fs, input int shi, input int slo,
                           input int fhi, input int flo,
                           input int hold, input int su);
    @(negedge clk);
    enable        = 1'b0;
    fast_sel      = fs;
    std_hi_cnt    = 16'(shi);
    std_lo_cnt    = 16'(slo);
    fast_hi_cnt   = 16'(fhi);
    fast_lo_cnt   = 16'(flo);
    sda_hold_cfg  = 9'(hold);
    sda_setup_cnt = 8'(su);
    @(negedge clk);
    enable = 1'b1;
  endtask

  // start, two falls, then a stop; returns the cycle of each strobe
  task automatic run_frame(input int stretch, output int ts, output int tf,
                           output int td, output int tr, output int tf2,
                           output int tstop);
    int hold_left;
    bit stop_sent;
    ts = -1; tf = -1; td = -1; tr = -1; tf2 = -1; tstop = -1;
    hold_left = 0;
    stop_sent = 0;
    @(negedge clk);
    start_req = 1'b1;
    for (int n = 0; n < 3000 && tstop < 0; n++) begin
      @(negedge clk);
      start_req = 1'b0;
      stop_req  = 1'b0;
      if (start_stb) ts = cyc;
      if (scl_fall_stb) begin
        if (tf < 0) tf = cyc;
        else if (tf2 < 0) tf2 = cyc;
      end
      if (sda_chg_stb && td < 0) td = cyc;
      if (scl_rise_stb && tr < 0) begin
        tr = cyc;
        hold_left = stretch;
      end
      slave_hold = (hold_left > 0);
      if (hold_left > 0) hold_left--;
      if (tf2 >= 0 && !stop_sent) begin
        stop_req  = 1'b1;
        stop_sent = 1;
      end
      if (stop_stb) tstop = cyc;
    end
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 scl_drive_low", int'(scl_drive_low), 0);
    chk("R1 strobes", int'({scl_fall_stb, scl_rise_stb, sda_chg_stb,
                            start_stb, stop_stb}), 0);
  endtask

  task automatic t_std();
    int ts, tf, td, tr, tf2, tsp;
    setup_cfg(0, 15, 20, 7, 10, 9'h104, 1);
    run_frame(0, ts, tf, td, tr, tf2, tsp);
    chk("R10 start to first fall", tf - ts, 15);
    chk("R2 std low period", tr - tf, 20);
    chk("R2 std high period", tf2 - tr, 15);
    chk("R5 hold placement", td - tf, 5);
    chk("R11 stop after release", tsp - tf2, 35);
    repeat (3) @(negedge clk);
    chk("R11 idle after stop", int'(scl_drive_low || scl_fall_stb), 0);
  endtask

  task automatic t_fast();
    int ts, tf, td, tr, tf2, tsp;
    setup_cfg(1, 15, 20, 7, 10, 9'h104, 1);
    run_frame(0, ts, tf, td, tr, tf2, tsp);
    chk("R3 fast low period", tr - tf, 10);
    chk("R3 fast high period", tf2 - tr, 7);
    chk("R3 fast start hold", tf - ts, 7);
  endtask

  task automatic t_clamp();
    int ts, tf, td, tr, tf2, tsp;
    setup_cfg(0, 2, 3, 7, 10, 9'h104, 1);
    run_frame(0, ts, tf, td, tr, tf2, tsp);
    chk("R4 low floor", tr - tf, 8);
    chk("R4 high floor", tf2 - tr, 6);
  endtask

  task automatic t_nohold();
    int ts, tf, td, tr, tf2, tsp;
    setup_cfg(0, 15, 20, 7, 10, 9'h004, 1);
    run_frame(0, ts, tf, td, tr, tf2, tsp);
    chk("R6 hold disabled", td - tf, 1);
  endtask

  task automatic t_setup();
    int ts, tf, td, tr, tf2, tsp;
    setup_cfg(0, 15, 20, 7, 10, 9'h11E, 6);
    run_frame(0, ts, tf, td, tr, tf2, tsp);
    chk("R7 change pulled back", td - tf, 15);
    chk("R7 setup before release", tr - td, 5);
  endtask

  task automatic t_stretch();
    int ts, tf, td, tr, tf2, tsp;
    setup_cfg(0, 15, 20, 7, 10, 9'h104, 1);
    run_frame(7, ts, tf, td, tr, tf2, tsp);
    chk("R8 stretched high", tf2 - tr, 22);
    chk("R8 low unaffected", tr - tf, 20);
  endtask

  task automatic t_lock();
    int ts, tf, td, tr, tf2, tsp;
    setup_cfg(0, 15, 20, 7, 10, 9'h104, 1);
    @(negedge clk);
    std_lo_cnt = 16'd30;
    std_hi_cnt = 16'd9;
    run_frame(0, ts, tf, td, tr, tf2, tsp);
    chk("R9 low frozen while enabled", tr - tf, 20);
    chk("R9 high frozen while enabled", tf2 - tr, 15);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    run_frame(0, ts, tf, td, tr, tf2, tsp);
    chk("R9 low taken when disabled", tr - tf, 30);
    chk("R9 high taken when disabled", tf2 - tr, 9);
  endtask

  task automatic t_disabled();
    int seen;
    setup_cfg(0, 15, 20, 7, 10, 9'h104, 1);
    @(negedge clk);
    enable    = 1'b0;
    start_req = 1'b1;
    seen = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (start_stb || scl_fall_stb || scl_drive_low) seen++;
    end
    start_req = 1'b0;
    chk("R12 start ignored while disabled", seen, 0);
    enable = 1'b1;
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (19) @(negedge clk);
    chk("R12 low phase reached", int'(scl_drive_low), 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R12 release on disable", int'(scl_drive_low), 0);
    enable = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; fast_sel = 1'b0;
    std_hi_cnt = 16'd15; std_lo_cnt = 16'd20;
    fast_hi_cnt = 16'd7; fast_lo_cnt = 16'd10;
    sda_hold_cfg = 9'h104; sda_setup_cnt = 8'd1;
    start_req = 1'b0; stop_req = 1'b0; slave_hold = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_std();
    t_fast();
    t_clamp();
    t_nohold();
    t_setup();
    t_stretch();
    t_lock();
    t_disabled();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule